// File: doc/BRIEF.md
# Address Attribute Chip-Select Generator

This block drives four attribute lines for an external memory access. Each line has its own match entry, made of a 12-bit base, a 12-bit mask, an enable bit and a polarity bit. The entry is compared with the upper twelve bits of the access address. Software programs the entries and a one-bit mode register through a plain valid/address/data write port.

In the default mode a fixed priority lets only one line go active: the lowest-numbered matching entry. When the priority-disable bit is set, every matching entry drives its line at the same time. The four lines then form a 4-bit code that board logic can decode into sixteen selects.

The lines are evaluated on the clock edge that opens an access and are held for the whole access. They return to their inactive level once the access ends, so they never carry stale values between accesses the way address lines do.

Top module: `attr_sel`

## Requirements
- R1: After reset every entry is disabled, the priority-disable bit is clear, every polarity bit is clear, and all four lines are low. An access made before any programming asserts no line.
- R2: A write with cfgAddr = i (0..3) loads entry i from cfgData: bits [11:0] are the base, bits [23:12] are the mask, bit 24 is the enable and bit 25 is the invert (polarity) bit.
- R3: A write with cfgAddr = 4 loads the priority-disable bit from cfgData[0]. Writes to cfgAddr 5..7 change nothing.
- R4: Entry i matches when it is enabled and (busAddrHi & mask) == (base & mask). A disabled entry never matches.
- R5: With the priority-disable bit clear, at most one line is active: the lowest-numbered matching entry.
- R6: With the priority-disable bit set, every matching entry's line is active at the same time.
- R7: An access starts when busActive is first sampled high after being low. The lines take their new value at that clock edge and keep it unchanged while busActive stays high.
- R8: On the clock edge that samples busActive low, every line returns to its inactive level.
- R9: With its invert bit set, a line is active-low: it idles high and drives low when active. With the bit clear, the line is active-high.
- R10: Writes that arrive while an access is active, including changes to the mode bit and the invert bits, leave that access's lines unchanged. They take effect from the next access on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busActive | input | 1 | High for the duration of an external access |
| busAddrHi | input | 12 | Upper address bits of the current access |
| cfgValid | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register write address (0..3 entries, 4 mode) |
| cfgData | input | 26 | Register write data |
| attrOut | output | 4 | Attribute lines, each at its programmed polarity |

## Verification
The bench uses the default package values: four entries, 12-bit tags and a 3-bit register address. With these values the whole register map can be reached, including the unused addresses 5 to 7. The bench confines random address tags to a small range and draws masks from a set that includes all-ones, partial and all-zeros masks. This makes overlapping matches common, so priority resolution and the four-bit combined code are both exercised often. Directed cases cover writes made in the middle of an access, polarity flips, and disabled entries that would otherwise match.

// File: rtl/attr_sel_pkg.sv
package attr_sel_pkg;
  parameter int ATTR_N = 4;
  parameter int TAG_W  = 12;
  localparam int CFG_W = 2 * TAG_W + 2;
  localparam int SEL_W = $clog2(ATTR_N + 1);
  localparam int EN_BIT  = 2 * TAG_W;
  localparam int INV_BIT = 2 * TAG_W + 1;

  typedef struct packed {
    logic              capture;
    logic              hold;
    logic              wrMode;
    logic [ATTR_N-1:0] wrEntry;
  } strobe_t;
endpackage

// File: rtl/attr_sel_ctrl.sv
module attr_sel_ctrl
  import attr_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             busActive,
  input  logic             cfgValid,
  input  logic [SEL_W-1:0] cfgAddr,
  output strobe_t          strobe
);
  logic prevActive;

  always_ff @(posedge clk) begin
    if (rst) prevActive <= 1'b0;
    else     prevActive <= busActive;
  end

  always_comb begin
    strobe.capture = busActive & ~prevActive;
    strobe.hold    = busActive & prevActive;
    strobe.wrMode  = cfgValid && (cfgAddr == SEL_W'(ATTR_N));
  end

  for (genvar i = 0; i < ATTR_N; i++) begin : g_dec
    assign strobe.wrEntry[i] = cfgValid && (cfgAddr == SEL_W'(i));
  end
endmodule

// File: rtl/attr_sel_dp.sv
module attr_sel_dp
  import attr_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [TAG_W-1:0]  busAddrHi,
  input  logic [CFG_W-1:0]  cfgData,
  output logic [ATTR_N-1:0] attrOut
);
  logic [TAG_W-1:0]  baseCfg [ATTR_N];
  logic [TAG_W-1:0]  maskCfg [ATTR_N];
  logic [ATTR_N-1:0] enCfg;
  logic [ATTR_N-1:0] polCfg;
  logic              modeCfg;

  logic [ATTR_N-1:0] hit;
  logic [ATTR_N-1:0] grant;
  logic [ATTR_N-1:0] nextAct;

  logic [ATTR_N-1:0] actReg;
  logic [ATTR_N-1:0] polUse;
  logic              modeUse;

  // configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ATTR_N; i++) begin
        baseCfg[i] <= '0;
        maskCfg[i] <= '0;
      end
      enCfg   <= '0;
      polCfg  <= '0;
      modeCfg <= 1'b0;
    end else begin
      for (int i = 0; i < ATTR_N; i++) begin
        if (strobe.wrEntry[i]) begin
          baseCfg[i] <= cfgData[TAG_W-1:0];
          maskCfg[i] <= cfgData[2*TAG_W-1:TAG_W];
          enCfg[i]   <= cfgData[EN_BIT];
          polCfg[i]  <= cfgData[INV_BIT];
        end
      end
      if (strobe.wrMode) modeCfg <= cfgData[0];
    end
  end

  // per-entry compare
  for (genvar i = 0; i < ATTR_N; i++) begin : g_hit
    assign hit[i] = enCfg[i] &&
                    ((busAddrHi & maskCfg[i]) == (baseCfg[i] & maskCfg[i]));
  end

  // lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < ATTR_N; i++) begin
      if (hit[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign nextAct = modeCfg ? hit : grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      actReg  <= '0;
      polUse  <= '0;
      modeUse <= 1'b0;
    end else if (strobe.capture) begin
      actReg  <= nextAct;
      polUse  <= polCfg;
      modeUse <= modeCfg;
    end else if (!strobe.hold) begin
      actReg  <= '0;
      polUse  <= polCfg;
      modeUse <= modeCfg;
    end
  end

  assign attrOut = actReg ^ polUse;
endmodule

// File: rtl/attr_sel.sv
module attr_sel
  import attr_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busActive,
  input  logic [TAG_W-1:0]  busAddrHi,
  input  logic              cfgValid,
  input  logic [SEL_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  output logic [ATTR_N-1:0] attrOut
);
  strobe_t strobe;

  attr_sel_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .busActive (busActive),
    .cfgValid  (cfgValid),
    .cfgAddr   (cfgAddr),
    .strobe    (strobe)
  );

  attr_sel_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .busAddrHi (busAddrHi),
    .cfgData   (cfgData),
    .attrOut   (attrOut)
  );
endmodule

// File: rtl/attr_sel_chk.sv
module attr_sel_chk
  import attr_sel_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busActive,
  input logic [ATTR_N-1:0] attrOut,
  input logic [ATTR_N-1:0] actReg,
  input logic [ATTR_N-1:0] polCfg,
  input logic              modeUse
);
  // R5: priority mode never shows more than one active line
  assert_single_active_R5: assert property (@(posedge clk) disable iff (rst)
    !modeUse |-> $onehot0(actReg));

  // R8: an idle sample clears every active line on the next cycle
  assert_idle_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !busActive |=> (actReg == '0));

  // R7 and R10: lines hold while an access continues
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (busActive && $past(busActive)) |=> $stable(attrOut));

  // R9: idle level follows the programmed polarity
  assert_idle_level_R9: assert property (@(posedge clk) disable iff (rst)
    !busActive |=> (attrOut == $past(polCfg)));
endmodule

bind attr_sel attr_sel_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busActive (busActive),
  .attrOut   (attrOut),
  .actReg    (u_dp.actReg),
  .polCfg    (u_dp.polCfg),
  .modeUse   (u_dp.modeUse)
);

// File: tb/tb_attr_sel.sv
`timescale 1ns/1ps
module tb_attr_sel;
  import attr_sel_pkg::*;

  logic              clk = 1'b0;
  logic              rst;
  logic              busActive;
  logic [TAG_W-1:0]  busAddrHi;
  logic              cfgValid;
  logic [SEL_W-1:0]  cfgAddr;
  logic [CFG_W-1:0]  cfgData;
  logic [ATTR_N-1:0] attrOut;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [TAG_W-1:0]  mBase [ATTR_N];
  logic [TAG_W-1:0]  mMask [ATTR_N];
  logic [ATTR_N-1:0] mEn;
  logic [ATTR_N-1:0] mPol;
  logic              mOff;

  always #4 clk = ~clk;

  attr_sel dut (.*);

  function automatic logic [ATTR_N-1:0] expPins(input logic [TAG_W-1:0] tag);
    logic [ATTR_N-1:0] h, g;
    h = '0; g = '0;
    for (int i = 0; i < ATTR_N; i++)
      h[i] = mEn[i] && ((tag & mMask[i]) == (mBase[i] & mMask[i]));
    for (int i = 0; i < ATTR_N; i++)
      if (h[i]) begin g[i] = 1'b1; break; end
    return (mOff ? h : g) ^ mPol;
  endfunction

  function automatic logic [CFG_W-1:0] packEntry(input logic inv, input logic en,
      input logic [TAG_W-1:0] mask, input logic [TAG_W-1:0] base);
    return {inv, en, mask, base};
  endfunction

  task automatic check(input string req, input logic [ATTR_N-1:0] act,
                       input logic [ATTR_N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: attrOut=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one register write; caller is at a negedge
  task automatic wr(input int a, input logic [CFG_W-1:0] d);
    cfgValid = 1'b1;
    cfgAddr  = SEL_W'(a);
    cfgData  = d;
    @(negedge clk);
    cfgValid = 1'b0;
    if (a < ATTR_N) begin
      mBase[a] = d[TAG_W-1:0];
      mMask[a] = d[2*TAG_W-1:TAG_W];
      mEn[a]   = d[EN_BIT];
      mPol[a]  = d[INV_BIT];
    end else if (a == ATTR_N) begin
      mOff = d[0];
    end
  endtask

  // one access of len cycles, optional write in its middle
  task automatic access(input string req, input logic [TAG_W-1:0] tag,
                        input int len, input bit doW, input int wa,
                        input logic [CFG_W-1:0] wd);
    logic [ATTR_N-1:0] e;
    e = expPins(tag);
    busActive = 1'b1;
    busAddrHi = tag;
    @(negedge clk);
    check(req, attrOut, e);
    if (doW) begin
      wr(wa, wd);
      check("R10 write mid-access", attrOut, e);
    end
    for (int k = 1; k < len; k++) begin
      busAddrHi = TAG_W'($urandom);
      @(negedge clk);
      check("R7 hold", attrOut, e);
    end
    busActive = 1'b0;
    @(negedge clk);
    check("R8 idle", attrOut, mPol);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < ATTR_N; i++) begin mBase[i] = '0; mMask[i] = '0; end
    mEn = '0; mPol = '0; mOff = 1'b0;
    rst = 1'b1; busActive = 1'b0; busAddrHi = '0;
    cfgValid = 1'b0; cfgAddr = '0; cfgData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset lines", attrOut, 4'b0000);
    access("R1 unprogrammed access", 12'h001, 2, 0, 0, '0);

    // R2/R4/R5 directed
    wr(0, packEntry(0, 1, 12'hFFF, 12'h001));
    wr(1, packEntry(0, 1, 12'h000, 12'h000));
    wr(3, packEntry(0, 0, 12'hFFF, 12'h001));
    access("R5 lowest wins", 12'h001, 3, 0, 0, '0);
    check("R5 directed", expPins(12'h001), 4'b0001);
    access("R4 partial match", 12'h002, 2, 0, 0, '0);
    check("R4 directed", expPins(12'h002), 4'b0010);

    // R6 combined code; disabled entry 3 excluded
    wr(4, CFG_W'(1));
    access("R6 all matching", 12'h001, 2, 0, 0, '0);
    check("R6 directed", expPins(12'h001), 4'b0011);

    // R3 unused addresses ignored
    wr(5, '0);
    wr(7, '0);
    access("R3 unused address ignored", 12'h001, 1, 0, 0, '0);
    wr(6, '1);
    access("R3 unused address ignored 2", 12'h7F0, 1, 0, 0, '0);

    // R9 polarity
    wr(2, packEntry(1, 0, 12'hFFF, 12'h000));
    @(negedge clk);
    check("R9 idle high", attrOut, 4'b0100);
    wr(2, packEntry(1, 1, 12'hF00, 12'h300));
    access("R9 active low", 12'h345, 2, 0, 0, '0);

    // R10 write during access
    wr(4, CFG_W'(0));
    access("R10 before", 12'h001, 4, 1, 0, packEntry(0, 0, 12'hFFF, 12'h001));
    access("R10 next access", 12'h001, 2, 0, 0, '0);
    access("R10 mode change", 12'h001, 3, 1, 4, CFG_W'(1));
    access("R10 mode next", 12'h001, 2, 1, 1, packEntry(1, 1, 12'h000, 12'h000));
    access("R10 pol next", 12'h001, 2, 0, 0, '0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      if (($urandom % 3) == 0) begin
        int e;
        logic [TAG_W-1:0] m;
        e = int'($urandom % ATTR_N);
        case ($urandom % 4)
          0: m = 12'hFFF;
          1: m = 12'hFFC;
          2: m = 12'h000;
          default: m = TAG_W'($urandom);
        endcase
        wr(e, packEntry(1'($urandom), 1'($urandom), m, TAG_W'($urandom % 8)));
      end
      if (($urandom % 8) == 0) wr(4, CFG_W'($urandom % 2));
      access("R4/R5/R6 random", TAG_W'($urandom % 8), 1 + int'($urandom % 4),
             0, 0, '0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule